// File: doc/BRIEF.md
# LCD Frame Header Decoder

This block sits at the head of an LCD fetch engine and is consulted once per frame. When the engine strobes the start of a frame, the block reads the depth code in the first 16-bit palette word. It works out the pixel depth, the pixel format and the byte position where pixel data begins. It then checks that the configured picture fits in the active frame buffer.

A frame that fits is committed. The block latches its decode results and sets a per-buffer condition pulse. It may pulse a DMA interrupt, and in dual-buffer mode it switches to the other buffer. A frame that does not fit produces a sync-error pulse, and the engine is expected to drop its enable. A frame with an unsupported depth code is skipped. The subpanel setting can trim the drawn region, either by moving the first line or by limiting the number of lines.

The block keeps the active-buffer index itself. Each of the two buffers is described by a top and a bottom address, and its size is bottom minus top. Memory reads and pixel conversion take place elsewhere.

Top module: `lcd_hdr_decode`

## Requirements
- R1: The cycle after `startFrame` is sampled high, exactly one of `frameOk`, `syncErr` and `frameSkip` is high for one cycle. None of them is high in any other cycle.
- R2: The depth code is `paletteHead[14:12]`. Code 1 gives 2 bits per pixel, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16.
- R3: `pixFormat` is 0 for 2 bpp, 1 for 4 bpp and 2 for 8 bpp. At 16 bpp it is 4 when `tftMode` is 1 (16-bit colour) and 3 when `tftMode` is 0 (12-bit colour).
- R4: `dataOffset` is 0 when `loadMode` is 2. For any other `loadMode` it is 0x200 for codes 3 to 7 and 0x20 for codes 1 and 2.
- R5: When dataOffset + width*height*bpp/8 exceeds the active buffer size + 2, the frame ends with `syncErr`, and the decode outputs keep their previous values. At exactly size + 2 the frame is accepted.
- R6: The active buffer size is `frameBottom0 - frameTop0` when `activeFrame` is 0 and `frameBottom1 - frameTop1` when it is 1.
- R7: Depth code 0 ends the frame with `frameSkip`, and all decode outputs and `activeFrame` keep their values.
- R8: On `frameOk`, `frameCondSet` has the bit of the buffer index used (bit 0 or bit 1) set, and `dmaIrqPulse` equals `dmaIrqEn`. In every other cycle both are zero.
- R9: On `frameOk` with `dualMode` high, `activeFrame` toggles. It is unchanged on every other outcome, and on `frameOk` with `dualMode` low.
- R10: With `subpanelCfg[31]` clear, `firstLine` is 0 and `lineCount` is the height. With bit 31 set and bit 29 set, `firstLine` is `subpanelCfg[25:16]` and `lineCount` is the height. With bit 31 set and bit 29 clear, `firstLine` is 0 and `lineCount` is `subpanelCfg[25:16]`.
- R11: `lineStride` equals width*bpp/8 bytes.
- R12: After reset, all outputs are zero and `activeFrame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startFrame | input | 1 | One-cycle frame start strobe |
| paletteHead | input | 16 | First palette word; bits 14:12 carry the depth code |
| loadMode | input | 2 | Palette load mode; 2 means no palette ahead of pixel data |
| tftMode | input | 1 | Selects 16-bit colour rather than 12-bit at 16 bpp |
| dualMode | input | 1 | Alternate between the two buffers after each committed frame |
| dmaIrqEn | input | 1 | Pulse the DMA interrupt on a committed frame |
| lineWidth | input | 11 | Pixels per line (1 to 1024) |
| lineHeight | input | 11 | Lines per frame (1 to 1024) |
| frameTop0 | input | 32 | Start address of buffer 0 |
| frameBottom0 | input | 32 | End address of buffer 0 |
| frameTop1 | input | 32 | Start address of buffer 1 |
| frameBottom1 | input | 32 | End address of buffer 1 |
| subpanelCfg | input | 32 | Subpanel setting: bit 31 on, bit 29 mode, bits 25:16 line value |
| frameOk | output | 1 | Frame committed |
| syncErr | output | 1 | Picture does not fit in the buffer |
| frameSkip | output | 1 | Unsupported depth code |
| activeFrame | output | 1 | Current buffer index |
| frameCondSet | output | 2 | One-hot condition pulse for the buffer used |
| dmaIrqPulse | output | 1 | DMA interrupt pulse |
| bitsPerPixel | output | 5 | Decoded depth |
| pixFormat | output | 3 | Pixel format select |
| dataOffset | output | 10 | Byte offset of pixel data in the buffer |
| lineStride | output | 12 | Bytes per line |
| firstLine | output | 11 | First drawn line |
| lineCount | output | 11 | Number of drawn lines |

## Verification
Each outcome strobe, condition pulse and interrupt pulse is due in the single cycle after the start strobe is sampled. The decode outputs and the buffer index change at that same edge and then hold. The bench drives its inputs on the falling edge, holds the start strobe for one cycle, and reads every result on the next falling edge. That falling edge follows the one registering edge that produces the results. It then checks that the strobes are low again one cycle later, so a result that comes late or lasts too long is caught.

// File: rtl/lcd_hdr_pkg.sv
package lcd_hdr_pkg;

  typedef enum logic [2:0] {
    FMT_PAL2  = 3'd0,
    FMT_PAL4  = 3'd1,
    FMT_PAL8  = 3'd2,
    FMT_RGB12 = 3'd3,
    FMT_RGB16 = 3'd4
  } pixFmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the decode of the current frame
    logic selFrame;  // buffer index whose size is checked
  } ctrlStrb_t;

endpackage

// File: rtl/lcd_hdr_dp.sv
module lcd_hdr_dp
  import lcd_hdr_pkg::*;
#(
  parameter int DIM_W  = 11,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 10,
  parameter int BPP_W  = 5,
  parameter int NBUF   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrb_t                     strb,
  input  logic [15:0]                   paletteHead,
  input  logic [1:0]                    loadMode,
  input  logic                          tftMode,
  input  logic [DIM_W-1:0]              lineWidth,
  input  logic [DIM_W-1:0]              lineHeight,
  input  logic [NBUF-1:0][ADDR_W-1:0]   bufTop,
  input  logic [NBUF-1:0][ADDR_W-1:0]   bufBottom,
  input  logic [31:0]                   subpanelCfg,
  output logic                          codeValid,
  output logic                          fits,
  output logic [BPP_W-1:0]              bitsPerPixel,
  output logic [2:0]                    pixFormat,
  output logic [OFS_W-1:0]              dataOffset,
  output logic [DIM_W:0]                lineStride,
  output logic [DIM_W-1:0]              firstLine,
  output logic [DIM_W-1:0]              lineCount
);

  localparam int PROD_W   = 2 * DIM_W + BPP_W;
  localparam int EXT_W    = ADDR_W + 1;
  localparam int STRIDE_W = DIM_W + BPP_W;
  localparam int SPF_W    = 10;

  logic [2:0]        depthCode;
  logic [BPP_W-1:0]  bppNext;
  pixFmt_e           fmtNext;
  logic [OFS_W-1:0]  ofsNext;
  logic [ADDR_W-1:0] bufSize [NBUF];
  logic [ADDR_W-1:0] activeSize;
  logic [PROD_W-1:0] pixBits;
  logic [EXT_W-1:0]  needBytes;
  logic [EXT_W-1:0]  limitBytes;
  logic [STRIDE_W-1:0] strideBits;
  logic [DIM_W-1:0]  spField;
  logic [DIM_W-1:0]  firstNext;
  logic [DIM_W-1:0]  countNext;

  assign depthCode = paletteHead[14:12];
  assign codeValid = (depthCode != 3'd0);

  always_comb begin
    bppNext = '0;
    fmtNext = FMT_PAL2;
    unique case (depthCode)
      3'd1: begin bppNext = BPP_W'(2); fmtNext = FMT_PAL2; end
      3'd2: begin bppNext = BPP_W'(4); fmtNext = FMT_PAL4; end
      3'd3: begin bppNext = BPP_W'(8); fmtNext = FMT_PAL8; end
      3'd0: begin bppNext = '0;        fmtNext = FMT_PAL2; end
      default: begin
        bppNext = BPP_W'(16);
        fmtNext = tftMode ? FMT_RGB16 : FMT_RGB12;
      end
    endcase
  end

  always_comb begin
    if (loadMode == 2'd2)      ofsNext = '0;
    else if (depthCode >= 3'd3) ofsNext = OFS_W'(10'h200);
    else                        ofsNext = OFS_W'(10'h020);
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_size
    assign bufSize[b] = bufBottom[b] - bufTop[b];
  end

  assign activeSize = bufSize[strb.selFrame];
  assign pixBits    = PROD_W'(lineWidth) * PROD_W'(lineHeight) * PROD_W'(bppNext);
  assign needBytes  = EXT_W'(pixBits >> 3) + EXT_W'(ofsNext);
  assign limitBytes = EXT_W'(activeSize) + EXT_W'(2);
  assign fits       = (needBytes <= limitBytes);

  assign strideBits = STRIDE_W'(lineWidth) * STRIDE_W'(bppNext);

  assign spField = DIM_W'(subpanelCfg[16 +: SPF_W]);
  always_comb begin
    firstNext = '0;
    countNext = lineHeight;
    if (subpanelCfg[31]) begin
      if (subpanelCfg[29]) firstNext = spField;
      else                 countNext = spField;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitsPerPixel <= '0;
      pixFormat    <= '0;
      dataOffset   <= '0;
      lineStride   <= '0;
      firstLine    <= '0;
      lineCount    <= '0;
    end else if (strb.capture) begin
      bitsPerPixel <= bppNext;
      pixFormat    <= fmtNext;
      dataOffset   <= ofsNext;
      lineStride   <= (DIM_W+1)'(strideBits >> 3);
      firstLine    <= firstNext;
      lineCount    <= countNext;
    end
  end

endmodule

// File: rtl/lcd_hdr_ctrl.sv
module lcd_hdr_ctrl
  import lcd_hdr_pkg::*;
#(
  parameter int NBUF = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startFrame,
  input  logic            dualMode,
  input  logic            dmaIrqEn,
  input  logic            codeValid,
  input  logic            fits,
  output ctrlStrb_t       strb,
  output logic            frameOk,
  output logic            syncErr,
  output logic            frameSkip,
  output logic            activeFrame,
  output logic [NBUF-1:0] frameCondSet,
  output logic            dmaIrqPulse
);

  logic okNow, errNow, skipNow;

  assign skipNow = startFrame && !codeValid;
  assign errNow  = startFrame && codeValid && !fits;
  assign okNow   = startFrame && codeValid && fits;

  assign strb.capture  = okNow;
  assign strb.selFrame = activeFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameOk      <= 1'b0;
      syncErr      <= 1'b0;
      frameSkip    <= 1'b0;
      activeFrame  <= 1'b0;
      frameCondSet <= '0;
      dmaIrqPulse  <= 1'b0;
    end else begin
      frameOk      <= okNow;
      syncErr      <= errNow;
      frameSkip    <= skipNow;
      dmaIrqPulse  <= okNow && dmaIrqEn;
      frameCondSet <= okNow ? (NBUF'(1) << activeFrame) : '0;
      if (okNow && dualMode) activeFrame <= !activeFrame;
    end
  end

endmodule

// File: rtl/lcd_hdr_decode.sv
module lcd_hdr_decode
  import lcd_hdr_pkg::*;
#(
  parameter int DIM_W  = 11,
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 10,
  parameter int BPP_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startFrame,
  input  logic [15:0]       paletteHead,
  input  logic [1:0]        loadMode,
  input  logic              tftMode,
  input  logic              dualMode,
  input  logic              dmaIrqEn,
  input  logic [DIM_W-1:0]  lineWidth,
  input  logic [DIM_W-1:0]  lineHeight,
  input  logic [ADDR_W-1:0] frameTop0,
  input  logic [ADDR_W-1:0] frameBottom0,
  input  logic [ADDR_W-1:0] frameTop1,
  input  logic [ADDR_W-1:0] frameBottom1,
  input  logic [31:0]       subpanelCfg,
  output logic              frameOk,
  output logic              syncErr,
  output logic              frameSkip,
  output logic              activeFrame,
  output logic [1:0]        frameCondSet,
  output logic              dmaIrqPulse,
  output logic [BPP_W-1:0]  bitsPerPixel,
  output logic [2:0]        pixFormat,
  output logic [OFS_W-1:0]  dataOffset,
  output logic [DIM_W:0]    lineStride,
  output logic [DIM_W-1:0]  firstLine,
  output logic [DIM_W-1:0]  lineCount
);

  localparam int NBUF = 2;

  ctrlStrb_t strb;
  logic      codeValid;
  logic      fits;
  logic [NBUF-1:0][ADDR_W-1:0] bufTop;
  logic [NBUF-1:0][ADDR_W-1:0] bufBottom;

  assign bufTop    = {frameTop1, frameTop0};
  assign bufBottom = {frameBottom1, frameBottom0};

  lcd_hdr_ctrl #(.NBUF(NBUF)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .startFrame   (startFrame),
    .dualMode     (dualMode),
    .dmaIrqEn     (dmaIrqEn),
    .codeValid    (codeValid),
    .fits         (fits),
    .strb         (strb),
    .frameOk      (frameOk),
    .syncErr      (syncErr),
    .frameSkip    (frameSkip),
    .activeFrame  (activeFrame),
    .frameCondSet (frameCondSet),
    .dmaIrqPulse  (dmaIrqPulse)
  );

  lcd_hdr_dp #(
    .DIM_W (DIM_W),
    .ADDR_W(ADDR_W),
    .OFS_W (OFS_W),
    .BPP_W (BPP_W),
    .NBUF  (NBUF)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .paletteHead  (paletteHead),
    .loadMode     (loadMode),
    .tftMode      (tftMode),
    .lineWidth    (lineWidth),
    .lineHeight   (lineHeight),
    .bufTop       (bufTop),
    .bufBottom    (bufBottom),
    .subpanelCfg  (subpanelCfg),
    .codeValid    (codeValid),
    .fits         (fits),
    .bitsPerPixel (bitsPerPixel),
    .pixFormat    (pixFormat),
    .dataOffset   (dataOffset),
    .lineStride   (lineStride),
    .firstLine    (firstLine),
    .lineCount    (lineCount)
  );

endmodule

// File: rtl/lcd_hdr_decode_chk.sv
module lcd_hdr_decode_chk #(
  parameter int BPP_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             startFrame,
  input logic             dualMode,
  input logic             dmaIrqEn,
  input logic [15:0]      paletteHead,
  input logic             frameOk,
  input logic             syncErr,
  input logic             frameSkip,
  input logic             activeFrame,
  input logic [1:0]       frameCondSet,
  input logic             dmaIrqPulse,
  input logic [BPP_W-1:0] bitsPerPixel
);

  // R1: exactly one outcome after a start
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    startFrame |=> ($countones({frameOk, syncErr, frameSkip}) == 1));

  // R1: no outcome without a start the cycle before
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (frameOk || syncErr || frameSkip) |-> $past(startFrame));

  // R7: a skipped frame needs a zero depth code
  a_r7_skip_code: assert property (@(posedge clk) disable iff (!rstN)
    frameSkip |-> ($past(paletteHead[14:12]) == 3'd0));

  // R5 / R7: a failed or skipped frame leaves the depth unchanged
  a_r5_hold_depth: assert property (@(posedge clk) disable iff (!rstN)
    (syncErr || frameSkip) |-> $stable(bitsPerPixel));

  // R8: condition pulse one-hot exactly on a committed frame
  a_r8_cond_onehot: assert property (@(posedge clk) disable iff (!rstN)
    frameOk |-> ($countones(frameCondSet) == 1));

  a_r8_cond_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !frameOk |-> (frameCondSet == 2'b00) && !dmaIrqPulse);

  a_r8_irq_enable: assert property (@(posedge clk) disable iff (!rstN)
    frameOk |-> (dmaIrqPulse == $past(dmaIrqEn)));

  // R9: buffer index toggles only on a committed dual-mode frame
  a_r9_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (frameOk && $past(dualMode)) |-> (activeFrame != $past(activeFrame)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(frameOk && $past(dualMode)) |-> $stable(activeFrame));

endmodule

bind lcd_hdr_decode lcd_hdr_decode_chk #(.BPP_W(BPP_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .startFrame   (startFrame),
  .dualMode     (dualMode),
  .dmaIrqEn     (dmaIrqEn),
  .paletteHead  (paletteHead),
  .frameOk      (frameOk),
  .syncErr      (syncErr),
  .frameSkip    (frameSkip),
  .activeFrame  (activeFrame),
  .frameCondSet (frameCondSet),
  .dmaIrqPulse  (dmaIrqPulse),
  .bitsPerPixel (bitsPerPixel)
);

// File: tb/lcd_hdr_decode_tb.sv
module lcd_hdr_decode_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startFrame = 1'b0;
  logic [15:0] paletteHead = '0;
  logic [1:0]  loadMode = '0;
  logic        tftMode = 1'b0;
  logic        dualMode = 1'b0;
  logic        dmaIrqEn = 1'b0;
  logic [10:0] lineWidth = 11'd16;
  logic [10:0] lineHeight = 11'd8;
  logic [31:0] frameTop0 = 32'h1000;
  logic [31:0] frameBottom0 = 32'h1000 + 32'd4000;
  logic [31:0] frameTop1 = 32'h8000;
  logic [31:0] frameBottom1 = 32'h8000 + 32'd4000;
  logic [31:0] subpanelCfg = '0;

  logic        frameOk, syncErr, frameSkip, activeFrame, dmaIrqPulse;
  logic [1:0]  frameCondSet;
  logic [4:0]  bitsPerPixel;
  logic [2:0]  pixFormat;
  logic [9:0]  dataOffset;
  logic [11:0] lineStride;
  logic [10:0] firstLine, lineCount;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  lcd_hdr_decode dut_i (
    .clk(clk), .rstN(rstN), .startFrame(startFrame), .paletteHead(paletteHead),
    .loadMode(loadMode), .tftMode(tftMode), .dualMode(dualMode), .dmaIrqEn(dmaIrqEn),
    .lineWidth(lineWidth), .lineHeight(lineHeight),
    .frameTop0(frameTop0), .frameBottom0(frameBottom0),
    .frameTop1(frameTop1), .frameBottom1(frameBottom1),
    .subpanelCfg(subpanelCfg),
    .frameOk(frameOk), .syncErr(syncErr), .frameSkip(frameSkip),
    .activeFrame(activeFrame), .frameCondSet(frameCondSet), .dmaIrqPulse(dmaIrqPulse),
    .bitsPerPixel(bitsPerPixel), .pixFormat(pixFormat), .dataOffset(dataOffset),
    .lineStride(lineStride), .firstLine(firstLine), .lineCount(lineCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // set the geometry, pulse start, return on the falling edge after the result edge
  task automatic runFrame(input logic [2:0] code, input int w, input int h);
    @(negedge clk);
    paletteHead = {1'b0, code, 12'h0ab};
    lineWidth   = 11'(w);
    lineHeight  = 11'(h);
    startFrame  = 1'b1;
    @(negedge clk);
    startFrame  = 1'b0;
  endtask

  task automatic checkQuiet(input string tag);
    @(negedge clk);
    check({tag, " R1 strobes low after"}, {frameOk, syncErr, frameSkip, dmaIrqPulse}, 0);
    check({tag, " R8 cond low after"}, frameCondSet, 0);
  endtask

  task automatic setBuf0(input int size);
    frameBottom0 = frameTop0 + 32'(size);
  endtask

  task automatic tReset();
    check("R12 outcome strobes", {frameOk, syncErr, frameSkip}, 0);
    check("R12 activeFrame", activeFrame, 0);
    check("R12 bitsPerPixel", bitsPerPixel, 0);
    check("R12 dataOffset", dataOffset, 0);
    check("R12 lineCount", lineCount, 0);
  endtask

  task automatic tDepth8();
    loadMode = 2'd0; setBuf0(1000);
    runFrame(3'd3, 16, 8);        // 128 + 512 = 640 bytes
    check("R1 ok", frameOk, 1);
    check("R2 bpp code3", bitsPerPixel, 8);
    check("R3 fmt pal8", pixFormat, 2);
    check("R4 offset code3", dataOffset, 'h200);
    check("R11 stride 8bpp", lineStride, 16);
    check("R10 no subpanel first", firstLine, 0);
    check("R10 no subpanel count", lineCount, 8);
    check("R8 cond buf0", frameCondSet, 1);
    check("R8 irq disabled", dmaIrqPulse, 0);
    check("R9 no toggle single", activeFrame, 0);
    checkQuiet("depth8");
  endtask

  task automatic tDepth2Edge();
    loadMode = 2'd1; setBuf0(62);
    runFrame(3'd1, 32, 4);        // 32 + 32 = 64 = size + 2
    check("R5 edge accepted", frameOk, 1);
    check("R2 bpp code1", bitsPerPixel, 2);
    check("R3 fmt pal2", pixFormat, 0);
    check("R4 offset code1", dataOffset, 'h20);
    check("R11 stride 2bpp", lineStride, 8);
    setBuf0(61);
    runFrame(3'd2, 32, 4);        // 64 + 32 = 96 > 63
    check("R5 sync error", syncErr, 1);
    check("R5 no ok", frameOk, 0);
    check("R5 bpp held", bitsPerPixel, 2);
    check("R5 offset held", dataOffset, 'h20);
    check("R8 no cond on err", frameCondSet, 0);
    checkQuiet("depth2");
  endtask

  task automatic tNoPalette();
    loadMode = 2'd2; setBuf0(64);
    runFrame(3'd2, 32, 4);        // 64 + 0
    check("R1 ok mode2", frameOk, 1);
    check("R4 offset mode2", dataOffset, 0);
    check("R2 bpp code2", bitsPerPixel, 4);
    check("R3 fmt pal4", pixFormat, 1);
    loadMode = 2'd0; setBuf0(1000);
    runFrame(3'd2, 32, 4);
    check("R4 offset code2 palette", dataOffset, 'h20);
  endtask

  task automatic tDepth16();
    loadMode = 2'd0; setBuf0(4000);
    tftMode = 1'b1;
    runFrame(3'd5, 10, 20);       // 400 + 512
    check("R2 bpp code5", bitsPerPixel, 16);
    check("R3 fmt rgb16", pixFormat, 4);
    check("R11 stride 16bpp", lineStride, 20);
    tftMode = 1'b0;
    runFrame(3'd7, 10, 20);
    check("R3 fmt rgb12", pixFormat, 3);
    check("R4 offset code7", dataOffset, 'h200);
    setBuf0(909);                 // 912 > 911
    runFrame(3'd4, 10, 20);
    check("R5 16bpp err", syncErr, 1);
    setBuf0(4000);
  endtask

  task automatic tSkip();
    runFrame(3'd3, 16, 8);
    runFrame(3'd0, 100, 100);
    check("R7 skip strobe", frameSkip, 1);
    check("R7 no ok", frameOk, 0);
    check("R7 bpp held", bitsPerPixel, 8);
    check("R7 stride held", lineStride, 16);
    check("R7 frame held", activeFrame, 0);
    checkQuiet("skip");
  endtask

  task automatic tSubpanel();
    subpanelCfg = 32'hA003_0000;  // on, start mode, field 3
    runFrame(3'd3, 16, 40);
    check("R10 start mode first", firstLine, 3);
    check("R10 start mode count", lineCount, 40);
    subpanelCfg = 32'h8005_0000;  // on, count mode, field 5
    runFrame(3'd3, 16, 40);
    check("R10 count mode first", firstLine, 0);
    check("R10 count mode count", lineCount, 5);
    subpanelCfg = 32'h2007_0000;  // off
    runFrame(3'd3, 16, 40);
    check("R10 off first", firstLine, 0);
    check("R10 off count", lineCount, 40);
    subpanelCfg = '0;
  endtask

  task automatic tDual();
    dualMode = 1'b1; dmaIrqEn = 1'b1;
    setBuf0(4000);
    frameBottom1 = frameTop1 + 32'd100;
    runFrame(3'd3, 16, 8);        // 640 bytes fits buf0
    check("R8 cond buf0 dual", frameCondSet, 1);
    check("R8 irq enabled", dmaIrqPulse, 1);
    check("R9 toggle to 1", activeFrame, 1);
    runFrame(3'd3, 16, 8);        // buf1 holds 100: fails
    check("R6 buf1 size used", syncErr, 1);
    check("R9 no toggle on err", activeFrame, 1);
    frameBottom1 = frameTop1 + 32'd638;
    runFrame(3'd3, 16, 8);        // 640 <= 640
    check("R6 buf1 larger ok", frameOk, 1);
    check("R8 cond buf1", frameCondSet, 2);
    check("R9 toggle to 0", activeFrame, 0);
    setBuf0(100);
    runFrame(3'd3, 16, 8);
    check("R6 buf0 size used", syncErr, 1);
    check("R9 held after err", activeFrame, 0);
    dualMode = 1'b0; dmaIrqEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDepth8();
    tDepth2Edge();
    tNoPalette();
    tDepth16();
    tSkip();
    tSubpanel();
    tDual();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule